// File: doc/BRIEF.md
# Programmable Delay Trigger Generator

This block produces timed start pulses for a group of downstream converter channels. A start event launches a counter that advances once per prescaled count tick, from zero up to a programmable period limit. The counter then either wraps and keeps running, or stops at the limit and waits for the next start. Each channel owns a small set of pre-trigger outputs. Every pre-trigger has an enable bit, a select bit that chooses between "fire at my delay" and "fire at the start event", and a chaining bit that makes it follow the acknowledge of its lower neighbour in the same channel.

A separate compare value raises a sticky interrupt flag. The period, interrupt compare and all delay values are written into shadow buffers. They reach the live comparators only through a commit bit, and that commit is honoured only while the block is enabled. Software drives a simple write port: a register address, write data and a write strobe.

Register map (word addresses): 0 control, 1 period limit (shadow), 2 interrupt compare (shadow), 4+c channel c control, 8+c*NPT+k delay of pre-trigger k of channel c (shadow). Control bits: [0] enable, [1] continuous, [2] commit, [3] software start (self-clearing), [7:4] start source select, [10:8] prescale exponent, [12:11] multiplier code, [13] interrupt flag clear. Channel control bits: [7:0] enable mask, [15:8] delay-select mask, [23:16] chaining mask, with bit k of each field belonging to pre-trigger k.

Top module: `delay_trigger_gen`

## Requirements
- R1: After reset the count is 0, running is low, and every pre-trigger output, the interrupt flag and load_pending are low. The period limit resets to all ones and the other shadow and live values reset to 0.
- R2: While running, the count advances by one every (2^P)*M clocks. P is control bits [10:8]. M is 1, 10, 20 or 40 for multiplier codes 0, 1, 2 and 3 in control bits [12:11].
- R3: When a count tick arrives with the count at or above the live period limit, continuous mode (control bit 1 = 1) sets the count to 0 and keeps running. One-shot mode instead clears running and holds the count until the next start.
- R4: Source select 15 starts the counter from the software start bit (control bit 3). Source select s < 15 starts it from ext_trig[s]. A start is accepted only while the block is enabled and not running, and it loads count 0 one clock after the source is seen.
- R5: A pre-trigger with its enable and delay-select bits set gives a one-clock pulse in the clock where the count takes a value equal to its live delay. A pre-trigger with enable clear never pulses.
- R6: An enabled pre-trigger with delay-select clear pulses only in the clock where a start loads count 0, not on later wraps.
- R7: For pre-trigger k > 0 with its chaining bit set, the output pulses one clock after pt_ack of pre-trigger k-1 of the same channel, regardless of its delay. The chaining bit of pre-trigger 0 has no effect.
- R8: The interrupt flag rises in the clock where the count takes the live interrupt-compare value, stays high, and is cleared by writing control bit 13.
- R9: Writes to the period, interrupt-compare and delay registers do not change behaviour until a control write with commit and enable both set. load_pending is then high for exactly the next clock, and the shadow values are live from the clock after it.
- R10: A control write with the commit bit set and the enable bit clear commits nothing and leaves load_pending low.
- R11: With the block disabled, the count is forced to 0, running to low, every pre-trigger output to low and the interrupt flag to low, one clock after the enable clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address |
| wr_data | input | 32 | Register write data |
| ext_trig | input | 15 | Hardware start sources, selected by source select |
| pt_ack | input | NCH*NPT | Acknowledge from each converter input, index c*NPT+k |
| pt_out | output | NCH*NPT | One-clock pre-trigger pulses, index c*NPT+k |
| irq_flag | output | 1 | Sticky interrupt flag |
| load_pending | output | 1 | High for the clock in which shadow values are committed |
| count | output | CW | Current counter value |
| running | output | 1 | Counter is active |

## Verification
Properties are checked on every cycle for four behaviours. The counter only ever steps by one or returns to zero, and a fresh run always starts from zero. The live period moves only in the clock after a commit, where it takes the shadow value. The interrupt flag only rises on the interrupt-compare value. The disable path quiets everything one clock later. Other behaviours need directed scenarios against the bench's reference model, which is compared on every cycle: pulse counts per period, chained firing after an acknowledge, the ignored chaining bit on the first pre-trigger, prescaled tick spacing, one-shot hold, the rejected commit while disabled, and shadow writes that stay invisible until committed.

// File: rtl/pdt_pkg.sv
// Package: shared types and helpers for the delay trigger generator.
// Assumes the control word layout described in the brief.
package pdt_pkg;

    // Width of the prescaler counter: largest divide is 128 * 40 = 5120.
    localparam int PSW = 13;

    typedef struct packed {
        logic [1:0] mul;
        logic [2:0] pre;
        logic [3:0] sel;
        logic       cont;
        logic       en;
    } ctrl_t;

    // Multiplier code to factor.
    function automatic int unsigned mult_of(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 10;
            2'd2:    return 20;
            default: return 40;
        endcase
    endfunction

endpackage

// File: rtl/pdt_regs.sv
// Module: register file with shadow buffers and the commit path.
// Assumes one write per clock, NCH <= 4 and NCH*NPT <= 56 so the address map fits.
module pdt_regs
    import pdt_pkg::*;
#(
    parameter int NCH = 2,
    parameter int NPT = 2,
    parameter int CW  = 16,
    parameter int AW  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [31:0]                wr_data,
    output ctrl_t                      ctrl,
    output logic                       sw_go,
    output logic                       irq_clr,
    output logic                       load_pending,
    output logic [CW-1:0]              mod_act,
    output logic [CW-1:0]              mod_buf,
    output logic [CW-1:0]              idly_act,
    output logic [NCH*NPT-1:0][CW-1:0] dly_act,
    output logic [NCH-1:0][NPT-1:0]    ch_en,
    output logic [NCH-1:0][NPT-1:0]    ch_tos,
    output logic [NCH-1:0][NPT-1:0]    ch_b2b
);
    localparam int NPTR   = NCH * NPT;
    localparam int A_CTRL = 0;
    localparam int A_MOD  = 1;
    localparam int A_IDLY = 2;
    localparam int A_CH   = 4;
    localparam int A_DLY  = 8;

    logic                       ctrl_wr;
    logic                       ldok_q;
    logic [CW-1:0]              idly_buf;
    logic [NPTR-1:0][CW-1:0]    dly_buf;

    assign ctrl_wr      = wr_en && (wr_addr == AW'(A_CTRL));
    assign irq_clr      = ctrl_wr && wr_data[13];
    assign load_pending = ldok_q;

    // Control word fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.en   <= wr_data[0];
            ctrl.cont <= wr_data[1];
            ctrl.sel  <= wr_data[7:4];
            ctrl.pre  <= wr_data[10:8];
            ctrl.mul  <= wr_data[12:11];
        end
    end

    // Self-clearing software start and commit request (commit needs enable in the same write).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_go  <= 1'b0;
            ldok_q <= 1'b0;
        end else begin
            sw_go <= ctrl_wr && wr_data[3];
            if (ctrl_wr)     ldok_q <= wr_data[2] && wr_data[0];
            else if (ldok_q) ldok_q <= 1'b0;
        end
    end

    // Shadow buffers written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_buf  <= '1;
            idly_buf <= '0;
            dly_buf  <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(A_MOD))  mod_buf  <= wr_data[CW-1:0];
            if (wr_addr == AW'(A_IDLY)) idly_buf <= wr_data[CW-1:0];
            for (int i = 0; i < NPTR; i++)
                if (wr_addr == AW'(A_DLY + i)) dly_buf[i] <= wr_data[CW-1:0];
        end
    end

    // Live values, copied from the shadows in the commit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_act  <= '1;
            idly_act <= '0;
            dly_act  <= '0;
        end else if (ldok_q) begin
            mod_act  <= mod_buf;
            idly_act <= idly_buf;
            dly_act  <= dly_buf;
        end
    end

    // Per-channel mask words, unbuffered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_en  <= '0;
            ch_tos <= '0;
            ch_b2b <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NCH; c++)
                if (wr_addr == AW'(A_CH + c)) begin
                    ch_en[c]  <= wr_data[NPT-1:0];
                    ch_tos[c] <= wr_data[8 +: NPT];
                    ch_b2b[c] <= wr_data[16 +: NPT];
                end
        end
    end

endmodule

// File: rtl/pdt_counter.sv
// Module: start selection, prescaler, period counter and interrupt flag.
// Assumes the source select picks from {software start, ext_trig[14:0]}.
// Exposes the next count and event strobes so the pre-trigger stages register in step.
module pdt_counter
    import pdt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic          sw_go,
    input  logic [14:0]   ext_trig,
    input  logic [CW-1:0] mod_act,
    input  logic [CW-1:0] idly_act,
    input  logic          irq_clr,
    output logic [CW-1:0] count,
    output logic          running,
    output logic [CW-1:0] cnt_next,
    output logic          cnt_evt,
    output logic          start_evt,
    output logic          irq_flag
);
    logic [15:0]    src;
    logic           start_req;
    logic [PSW-1:0] div_last;
    logic [PSW-1:0] pc_q, pc_n;
    logic           run_n;

    assign src       = {sw_go, ext_trig};
    assign start_req = src[ctrl.sel];

    // Last prescaler state: (2^P) * M - 1.
    always_comb div_last = PSW'((32'd1 << ctrl.pre) * mult_of(ctrl.mul) - 32'd1);

    // Next-state for count, prescaler and run flag.
    always_comb begin
        cnt_next  = count;
        run_n     = running;
        pc_n      = pc_q;
        cnt_evt   = 1'b0;
        start_evt = 1'b0;
        if (!ctrl.en) begin
            cnt_next = '0;
            run_n    = 1'b0;
            pc_n     = '0;
        end else if (!running) begin
            if (start_req) begin
                start_evt = 1'b1;
                cnt_evt   = 1'b1;
                cnt_next  = '0;
                run_n     = 1'b1;
                pc_n      = '0;
            end
        end else if (pc_q == div_last) begin
            pc_n = '0;
            if (count >= mod_act) begin
                if (ctrl.cont) begin
                    cnt_next = '0;
                    cnt_evt  = 1'b1;
                end else begin
                    run_n = 1'b0;
                end
            end else begin
                cnt_next = count + 1'b1;
                cnt_evt  = 1'b1;
            end
        end else begin
            pc_n = pc_q + 1'b1;
        end
    end

    // Counter state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
            pc_q    <= '0;
        end else begin
            count   <= cnt_next;
            running <= run_n;
            pc_q    <= pc_n;
        end
    end

    // Sticky interrupt flag: set on compare, cleared by write, held low while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                irq_flag <= 1'b0;
        else if (!ctrl.en)                         irq_flag <= 1'b0;
        else if (cnt_evt && cnt_next == idly_act)  irq_flag <= 1'b1;
        else if (irq_clr)                          irq_flag <= 1'b0;
    end

endmodule

// File: rtl/pdt_pretrig.sv
// Module: pre-trigger pulse stage for one channel.
// Assumes the count event strobes are one clock wide; outputs are registered one-clock pulses.
// Pre-trigger 0 has no lower neighbour, so its chaining bit is not wired.
module pdt_pretrig #(
    parameter int NPT = 2,
    parameter int CW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blk_en,
    input  logic                   cnt_evt,
    input  logic                   start_evt,
    input  logic [CW-1:0]          cnt_next,
    input  logic [NPT-1:0][CW-1:0] dly,
    input  logic [NPT-1:0]         en,
    input  logic [NPT-1:0]         tos,
    input  logic [NPT-1:0]         b2b,
    input  logic [NPT-1:0]         ack,
    output logic [NPT-1:0]         pulse
);
    logic [NPT-1:0] fire;

    for (genvar k = 0; k < NPT; k++) begin : g_pt
        logic by_cmp;
        assign by_cmp = tos[k] ? (cnt_evt && cnt_next == dly[k]) : start_evt;
        if (k == 0) begin : g_head
            assign fire[k] = by_cmp;
        end else begin : g_chain
            assign fire[k] = b2b[k] ? ack[k-1] : by_cmp;
        end
    end

    // Registered, masked pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      pulse <= '0;
        else if (blk_en) pulse <= fire & en;
        else             pulse <= '0;
    end

endmodule

// File: rtl/delay_trigger_gen.sv
// Module: top of the programmable delay trigger generator.
// Assumes a single clock domain; ext_trig and pt_ack are synchronous to clk.
module delay_trigger_gen
    import pdt_pkg::*;
#(
    parameter int NCH = 2,
    parameter int NPT = 2,
    parameter int CW  = 16,
    parameter int AW  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [14:0]          ext_trig,
    input  logic [NCH*NPT-1:0]   pt_ack,
    output logic [NCH*NPT-1:0]   pt_out,
    output logic                 irq_flag,
    output logic                 load_pending,
    output logic [CW-1:0]        count,
    output logic                 running
);
    localparam int NPTR = NCH * NPT;

    ctrl_t                    ctrl_w;
    logic                     sw_go, irq_clr;
    logic                     blk_en;
    logic [CW-1:0]            mod_act, mod_buf, idly_act, cnt_next;
    logic                     cnt_evt, start_evt;
    logic [NPTR-1:0][CW-1:0]  dly_act;
    logic [NCH-1:0][NPT-1:0]  ch_en, ch_tos, ch_b2b;

    assign blk_en = ctrl_w.en;

    pdt_regs #(.NCH(NCH), .NPT(NPT), .CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl_w), .sw_go(sw_go), .irq_clr(irq_clr), .load_pending(load_pending),
        .mod_act(mod_act), .mod_buf(mod_buf), .idly_act(idly_act), .dly_act(dly_act),
        .ch_en(ch_en), .ch_tos(ch_tos), .ch_b2b(ch_b2b)
    );

    pdt_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_w), .sw_go(sw_go), .ext_trig(ext_trig),
        .mod_act(mod_act), .idly_act(idly_act), .irq_clr(irq_clr),
        .count(count), .running(running), .cnt_next(cnt_next),
        .cnt_evt(cnt_evt), .start_evt(start_evt), .irq_flag(irq_flag)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pdt_pretrig #(.NPT(NPT), .CW(CW)) u_pt (
            .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .cnt_evt(cnt_evt),
            .start_evt(start_evt), .cnt_next(cnt_next),
            .dly(dly_act[c*NPT +: NPT]), .en(ch_en[c]), .tos(ch_tos[c]), .b2b(ch_b2b[c]),
            .ack(pt_ack[c*NPT +: NPT]), .pulse(pt_out[c*NPT +: NPT])
        );
    end

endmodule

// File: rtl/pdt_checker.sv
// Module: property checker for the delay trigger generator, bound to the top.
// Assumes it observes the top's ports and its live and shadow period registers.
module pdt_checker #(
    parameter int CW   = 16,
    parameter int NPTR = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            blk_en,
    input logic            running,
    input logic [CW-1:0]   count,
    input logic [CW-1:0]   mod_act,
    input logic [CW-1:0]   mod_buf,
    input logic [CW-1:0]   idly_act,
    input logic            load_pending,
    input logic            irq_flag,
    input logic [NPTR-1:0] pt_out
);
    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> (count == '0 && !running && pt_out == '0 && !irq_flag));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && count != $past(count))
            |-> (count == $past(count) + 1'b1 || count == '0));

    // R4
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> count == '0);

    // R8
    irq_at_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> count == $past(idly_act));

    // R9
    commit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pending |=> mod_act == $past(mod_buf));

    // R10
    hold_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pending |=> $stable(mod_act));

endmodule

bind delay_trigger_gen pdt_checker #(.CW(CW), .NPTR(NPTR)) u_chk (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .running(running), .count(count),
    .mod_act(mod_act), .mod_buf(mod_buf), .idly_act(idly_act),
    .load_pending(load_pending), .irq_flag(irq_flag), .pt_out(pt_out)
);

// File: tb/sim_delay_trigger_gen.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module sim_delay_trigger_gen;
    localparam int NCH = 2;
    localparam int NPT = 2;
    localparam int NPTR = NCH * NPT;
    localparam int CW = 16;
    localparam int AW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [14:0]       ext_trig = '0;
    logic [NPTR-1:0]   pt_ack = '0;
    logic [NPTR-1:0]   pt_out;
    logic              irq_flag, load_pending, running;
    logic [CW-1:0]     count;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;
    string cur_req = "R1";

    delay_trigger_gen #(.NCH(NCH), .NPT(NPT), .CW(CW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_trig(ext_trig), .pt_ack(pt_ack), .pt_out(pt_out), .irq_flag(irq_flag),
        .load_pending(load_pending), .count(count), .running(running)
    );

    always #5 clk = ~clk;

    // Reference model state
    int m_en, m_cont, m_sel, m_pre, m_mul, m_sw, m_ld;
    int mod_b, mod_a, idly_b, idly_a;
    int dly_b[NPTR];
    int dly_a[NPTR];
    int cen[NCH];
    int ctos[NCH];
    int cb2b[NCH];
    int m_cnt, m_run, m_pc, m_irq;
    bit [NPTR-1:0] m_pt;

    function automatic int mulv(int code);
        if (code == 0) return 1;
        if (code == 1) return 10;
        if (code == 2) return 20;
        return 40;
    endfunction

    always @(posedge clk) begin : model
        int dv, nc, st, ev, sev, c, k, f;
        if (!rst_n) begin
            m_en = 0; m_cont = 0; m_sel = 0; m_pre = 0; m_mul = 0; m_sw = 0; m_ld = 0;
            mod_b = 65535; mod_a = 65535; idly_b = 0; idly_a = 0;
            for (int i = 0; i < NPTR; i++) begin dly_b[i] = 0; dly_a[i] = 0; end
            for (int i = 0; i < NCH; i++) begin cen[i] = 0; ctos[i] = 0; cb2b[i] = 0; end
            m_cnt = 0; m_run = 0; m_pc = 0; m_irq = 0; m_pt = '0;
        end else begin
            dv = (1 << m_pre) * mulv(m_mul);
            st = (m_sel == 15) ? m_sw : int'(ext_trig[m_sel]);
            ev = 0; sev = 0; nc = m_cnt;
            if (m_en == 0) begin
                nc = 0; m_run = 0; m_pc = 0;
            end else if (m_run == 0) begin
                if (st != 0) begin sev = 1; ev = 1; nc = 0; m_run = 1; m_pc = 0; end
            end else if (m_pc == dv - 1) begin
                m_pc = 0;
                if (m_cnt >= mod_a) begin
                    if (m_cont != 0) begin nc = 0; ev = 1; end
                    else m_run = 0;
                end else begin
                    nc = m_cnt + 1; ev = 1;
                end
            end else begin
                m_pc = m_pc + 1;
            end
            for (int i = 0; i < NPTR; i++) begin
                c = i / NPT; k = i % NPT;
                if (k > 0 && cb2b[c][k]) f = int'(pt_ack[i-1]);
                else if (ctos[c][k]) f = (ev != 0 && nc == dly_a[i]) ? 1 : 0;
                else f = sev;
                m_pt[i] = (m_en != 0 && cen[c][k] && f != 0);
            end
            if (m_en == 0) m_irq = 0;
            else if (ev != 0 && nc == idly_a) m_irq = 1;
            else if (wr_en && wr_addr == 0 && wr_data[13]) m_irq = 0;
            m_cnt = nc;
            if (m_ld != 0) begin
                mod_a = mod_b; idly_a = idly_b;
                for (int i = 0; i < NPTR; i++) dly_a[i] = dly_b[i];
                m_ld = 0;
            end
            m_sw = 0;
            if (wr_en) begin
                if (wr_addr == 0) begin
                    m_en = wr_data[0]; m_cont = wr_data[1]; m_sel = wr_data[7:4];
                    m_pre = wr_data[10:8]; m_mul = wr_data[12:11];
                    m_sw = wr_data[3];
                    m_ld = (wr_data[2] && wr_data[0]) ? 1 : 0;
                end
                if (wr_addr == 1) mod_b = wr_data[15:0];
                if (wr_addr == 2) idly_b = wr_data[15:0];
                for (int i = 0; i < NCH; i++)
                    if (wr_addr == AW'(4 + i)) begin
                        cen[i] = wr_data[NPT-1:0]; ctos[i] = wr_data[8 +: NPT];
                        cb2b[i] = wr_data[16 +: NPT];
                    end
                for (int i = 0; i < NPTR; i++)
                    if (wr_addr == AW'(8 + i)) dly_b[i] = wr_data[15:0];
            end
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            checks++;
            if (pt_out !== m_pt || irq_flag !== 1'(m_irq) || count !== CW'(m_cnt) ||
                running !== 1'(m_run) || load_pending !== 1'(m_ld)) begin
                errors++;
                $display("FAIL %s cycle %0d: pt=%b irq=%b cnt=%0d run=%b ld=%b expected pt=%b irq=%0d cnt=%0d run=%0d ld=%0d",
                         cur_req, cyc, pt_out, irq_flag, count, running, load_pending,
                         m_pt, m_irq, m_cnt, m_run, m_ld);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL R1 watchdog: cycles=%0d expected<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    int mx, np0, np3;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 running", int'(running), 0);
        chk("R1 pt_out", int'(pt_out), 0);
        chk("R1 irq/load", int'({irq_flag, load_pending}), 0);

        // R9 shadow writes, R10 rejected commit while disabled
        cur_req = "R9";
        wr(1, 9); wr(2, 5);
        wr(8, 3); wr(9, 7); wr(10, 0); wr(11, 2);
        wr(4, 3 | (3 << 8));
        wr(5, 3 | (1 << 8) | (2 << 16));
        cur_req = "R10";
        wr(0, 32'h4);
        chk("R10 load_pending", int'(load_pending), 0);
        cur_req = "R9";
        wr(0, 32'hF7);
        chk("R9 load_pending high", int'(load_pending), 1);
        @(negedge clk);
        chk("R9 load_pending one clock", int'(load_pending), 0);

        // R5/R7 continuous run with software start
        cur_req = "R5";
        wr(0, 32'hFB);
        repeat (3) @(negedge clk);
        mx = 0; np0 = 0; np3 = 0;
        for (int i = 0; i < 30; i++) begin
            pt_ack[2] = (i == 12);
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
            if (pt_out[0]) np0++;
            if (pt_out[3]) np3++;
        end
        pt_ack = '0;
        chk("R3 wrap at committed limit", mx, 9);
        chk("R5 pulses per 30 clocks", np0, 3);
        chk("R7 chained pulses", np3, 1);

        // R9 uncommitted period write is invisible
        cur_req = "R9";
        wr(1, 4);
        mx = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        chk("R9 old limit still live", mx, 9);
        wr(0, 32'hF7);
        repeat (12) @(negedge clk);
        mx = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        chk("R9 new limit live", mx, 4);

        // R8 interrupt flag sticky and cleared by write
        cur_req = "R8";
        chk("R8 flag set", int'(irq_flag), 1);
        wr(0, 32'hF3 | (1 << 13));
        repeat (2) @(negedge clk);
        chk("R8 flag cleared", int'(irq_flag), 0);

        // R11 disable
        cur_req = "R11";
        wr(0, 0);
        @(negedge clk);
        chk("R11 count", int'(count), 0);
        chk("R11 running/irq/pt", int'({running, irq_flag, pt_out}), 0);

        // R4 source select, R2 prescale, R3 one-shot hold
        cur_req = "R4";
        wr(1, 3);
        wr(0, 1 | (2 << 4) | (1 << 8) | (1 << 11) | 4);
        @(negedge clk);
        ext_trig[5] = 1'b1; @(negedge clk); ext_trig = '0;
        @(negedge clk);
        chk("R4 unselected source ignored", int'(running), 0);
        ext_trig[2] = 1'b1; @(negedge clk); ext_trig = '0;
        @(negedge clk);
        chk("R4 started", int'(running), 1);
        chk("R4 start count", int'(count), 0);
        cur_req = "R2";
        repeat (18) @(negedge clk);
        chk("R2 count before tick", int'(count), 0);
        @(negedge clk);
        chk("R2 count after 20 clocks", int'(count), 1);
        cur_req = "R3";
        repeat (100) @(negedge clk);
        chk("R3 one-shot stopped", int'(running), 0);
        chk("R3 one-shot hold", int'(count), 3);
        ext_trig[2] = 1'b1; @(negedge clk); ext_trig = '0;
        @(negedge clk);
        chk("R3 restart", int'({running, count == 0}), 3);

        // R6 start-only firing, R7 chaining bit of pre-trigger 0 ignored
        cur_req = "R6";
        wr(0, 0);
        wr(4, 1 | (1 << 16));
        wr(0, 32'hFB);
        np0 = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (pt_out[0]) np0++;
        end
        chk("R6 R7 single start pulse", np0, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule